// File: doc/BRIEF.md
# Single-Cycle Integer Square Root

This block takes an unsigned integer and returns the floor of its square root one clock later. A new operand can be accepted on every clock, so a stream of inputs gives a stream of roots at the same rate. The default operand width is 32 bits, which gives a 16-bit root.

Inside, the root is found one bit at a time, starting at the most significant bit. Each bit is decided by a stage that proposes setting that bit. All stages are unrolled into one combinational path that ends at the output register. No stage uses a multiplier. The square of the candidate root is kept as a running sum: the weight squared and twice the weight times the partial root are both fixed shifts. So each stage needs only an adder, a comparator and a multiplexer.

The input side has no register. The operand should come from a register upstream, so the whole chain fits within one clock period.

Top module: `isqrt_unit`

## Requirements
- R1: For every accepted operand v, the returned root r satisfies r*r <= v < (r+1)*(r+1).
- R2: out_valid is high in exactly the cycle after a cycle in which in_valid was high, and low after a cycle in which in_valid was low.
- R3: The trial-square arithmetic does not wrap at the top of the range. An operand with all bits set (0xFFFFFFFF at the default width) yields a root with all bits set (0xFFFF).
- R4: While rst_n is low, out_valid and out_root are both zero, and asserting rst_n clears them without waiting for a clock edge.
- R5: In a cycle where in_valid is low, out_root keeps its previous value, whatever in_data carries.
- R6: For every perfect square k*k the root is exactly k, and for k*k-1 (k >= 1) it is exactly k-1.
- R7: Operands 0, 1, 2 and 3 yield roots 0, 1, 1 and 1.
- R8: Operands presented on consecutive cycles each produce their own correct root on the consecutive following cycles, with no bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low. Asserts asynchronously and is released synchronously. |
| in_valid | input | 1 | High when in_data carries an operand |
| in_data | input | IN_W (32) | Unsigned operand |
| out_valid | output | 1 | High when out_root holds the root of the operand from the previous cycle |
| out_root | output | IN_W/2 (16) | Floor square root, held while no operand arrives |

## Verification
The bench builds the block with its default 32-bit operand and 16-bit root, the widest point where the running square can come close to overflow. At that width the all-ones operand, the ends of the perfect-square sweep up to 65535 and random 32-bit values exercise the carry headroom of the trial sum. They also exercise every one of the sixteen unrolled decision stages. Back-to-back streams, gaps with changing data, and a reset in the middle of a run cover the output register's enable and clear paths.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

  localparam int unsigned ISQ_DEF_IN_W = 32;

  // root width for an operand of w bits (w expected even)
  function automatic int unsigned isq_root_w(input int unsigned w);
    return (w + 1) / 2;
  endfunction

  // running-square width: two guard bits keep the trial sum from wrapping
  function automatic int unsigned isq_acc_w(input int unsigned w);
    return w + 2;
  endfunction

endpackage

// File: rtl/isqrt_step.sv
// One decision stage: try to set root bit BIT.
module isqrt_step #(
  parameter int unsigned IN_W   = 32,
  parameter int unsigned ROOT_W = 16,
  parameter int unsigned ACC_W  = 34,
  parameter int unsigned BIT    = 15
) (
  input  logic [IN_W-1:0]   radicand,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [ROOT_W-1:0] root_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [ROOT_W-1:0] root_o
);

  localparam logic [ACC_W-1:0]  WEIGHT_SQ = ACC_W'(1) << (2 * BIT);
  localparam logic [ROOT_W-1:0] WEIGHT    = ROOT_W'(1) << BIT;

  logic [ACC_W-1:0] cross_term;
  logic [ACC_W-1:0] trial;
  logic             fits;

  always_comb begin
    cross_term = ACC_W'(root_i) << (BIT + 1);
    trial      = acc_i + WEIGHT_SQ + cross_term;
    fits       = (trial <= ACC_W'(radicand));
    acc_o      = fits ? trial : acc_i;
    root_o     = fits ? (root_i | WEIGHT) : root_i;
  end

endmodule

// File: rtl/isqrt_chain.sv
// Unrolled chain of decision stages, MSB first.
module isqrt_chain #(
  parameter int unsigned IN_W   = 32,
  parameter int unsigned ROOT_W = 16,
  parameter int unsigned ACC_W  = 34
) (
  input  logic [IN_W-1:0]   radicand,
  output logic [ROOT_W-1:0] root,
  output logic [ACC_W-1:0]  square
);

  logic [ACC_W-1:0]  acc_w  [0:ROOT_W];
  logic [ROOT_W-1:0] root_w [0:ROOT_W];

  assign acc_w[0]  = '0;
  assign root_w[0] = '0;

  for (genvar k = 0; k < ROOT_W; k++) begin : g_step
    isqrt_step #(
      .IN_W  (IN_W),
      .ROOT_W(ROOT_W),
      .ACC_W (ACC_W),
      .BIT   (ROOT_W - 1 - k)
    ) u_step (
      .radicand(radicand),
      .acc_i   (acc_w[k]),
      .root_i  (root_w[k]),
      .acc_o   (acc_w[k+1]),
      .root_o  (root_w[k+1])
    );
  end

  assign root   = root_w[ROOT_W];
  assign square = acc_w[ROOT_W];

endmodule

// File: rtl/isqrt_unit.sv
module isqrt_unit
  import isqrt_pkg::*;
#(
  parameter int unsigned IN_W = ISQ_DEF_IN_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [IN_W-1:0]             in_data,
  output logic                        out_valid,
  output logic [isq_root_w(IN_W)-1:0] out_root
);

  localparam int unsigned ROOT_W = isq_root_w(IN_W);
  localparam int unsigned ACC_W  = isq_acc_w(IN_W);

  logic [ROOT_W-1:0] chain_root;
  logic [ACC_W-1:0]  chain_sq;
  logic [ROOT_W-1:0] root_d, root_q;
  logic              vld_d, vld_q;
  logic              root_en;

  isqrt_chain #(
    .IN_W  (IN_W),
    .ROOT_W(ROOT_W),
    .ACC_W (ACC_W)
  ) u_chain (
    .radicand(in_data),
    .root    (chain_root),
    .square  (chain_sq)
  );

  // next state
  always_comb begin
    root_en = in_valid;
    vld_d   = in_valid;
    root_d  = chain_root;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= '0;
    end else if (root_en) begin
      root_q <= root_d;
    end
  end

  assign out_valid = vld_q;
  assign out_root  = root_q;

endmodule

// File: rtl/isqrt_unit_chk.sv
module isqrt_unit_chk #(
  parameter int unsigned IN_W   = 32,
  parameter int unsigned ROOT_W = 16,
  parameter int unsigned ACC_W  = 34
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [IN_W-1:0]   in_data,
  input logic              out_valid,
  input logic [ROOT_W-1:0] out_root,
  input logic [ROOT_W-1:0] chain_root,
  input logic [ACC_W-1:0]  chain_sq
);

  localparam int unsigned W2 = 2 * ROOT_W + 2;

  logic [W2-1:0] r_lo, r_hi, c_sq;
  logic          seen_edge = 1'b0;

  assign r_lo = W2'(out_root) * W2'(out_root);
  assign r_hi = (W2'(out_root) + W2'(1)) * (W2'(out_root) + W2'(1));
  assign c_sq = W2'(chain_root) * W2'(chain_root);

  always @(posedge clk) seen_edge <= 1'b1;

  always @(negedge clk) begin
    if (seen_edge && !rst_n) begin
      assert_reset_clear_R4: assert (!out_valid && out_root == '0)
        else $error("reset did not clear outputs");
    end
  end

  assert_valid_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (r_lo <= W2'($past(in_data))) && (r_hi > W2'($past(in_data))));

  assert_square_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (W2'(chain_sq) == c_sq) && (chain_sq <= ACC_W'(in_data)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_root));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == '1) |=> out_root == '1);

endmodule

bind isqrt_unit isqrt_unit_chk #(
  .IN_W  (IN_W),
  .ROOT_W(ROOT_W),
  .ACC_W (ACC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_root  (out_root),
  .chain_root(chain_root),
  .chain_sq  (chain_sq)
);

// File: tb/isqrt_unit_test.sv
`timescale 1ns/1ps
module isqrt_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_root;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  isqrt_unit #(.IN_W(32)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_root (out_root)
  );

  function automatic longint unsigned ref_root(input longint unsigned v);
    longint unsigned r;
    r = longint'($floor($sqrt(real'(v))));
    while (r * r > v) r--;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic check_root(input logic [31:0] v, input string req);
    longint unsigned r, e;
    r = out_root;
    e = ref_root(v);
    check(out_valid === 1'b1, "R2", out_valid, 1);
    check(out_root === e[15:0], req, r, e);
    check(r * r <= v && (r + 1) * (r + 1) > v, "R1", r, e);
  endtask

  task automatic send(input logic [31:0] v, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    @(negedge clk);
    in_valid = 1'b0;
    check_root(v, req);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R4", out_valid, 0);
    check(out_root === 16'h0, "R4", out_root, 0);
    rst_n = 1'b1;
  endtask

  task automatic test_small();
    send(32'd0, "R7");
    send(32'd1, "R7");
    send(32'd2, "R7");
    send(32'd3, "R7");
    send(32'd4, "R7");
  endtask

  task automatic test_top();
    send(32'hFFFF_FFFF, "R3");
    check(out_root === 16'hFFFF, "R3", out_root, 16'hFFFF);
    send(32'hFFFE_0001, "R3");
    send(32'hFFFE_0000, "R3");
  endtask

  task automatic test_squares();
    for (int k = 1; k <= 65535; k += 97) begin
      send(32'(k * k), "R6");
      send(32'(k * k - 1), "R6");
    end
    send(32'hFFFE_0001, "R6");
    send(32'hFFFE_0000, "R6");
  endtask

  task automatic test_gap_hold();
    logic [15:0] held;
    send(32'd1000000, "R1");
    held = out_root;
    for (int i = 0; i < 4; i++) begin
      in_data = 32'(i * 7919 + 12345);
      @(negedge clk);
      check(out_valid === 1'b0, "R2", out_valid, 0);
      check(out_root === held, "R5", out_root, held);
    end
  endtask

  task automatic test_stream();
    logic [31:0] vals [0:15];
    for (int i = 0; i < 16; i++) vals[i] = $urandom();
    for (int i = 0; i <= 16; i++) begin
      @(negedge clk);
      if (i > 0) check_root(vals[i-1], "R8");
      if (i < 16) begin
        in_valid = 1'b1;
        in_data  = vals[i];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic test_random();
    for (int i = 0; i < 2000; i++) send($urandom(), "R1");
  endtask

  task automatic test_mid_reset();
    send(32'd144, "R4");
    #1;
    rst_n = 1'b0;
    #0.5;
    check(out_valid === 1'b0, "R4", out_valid, 0);
    check(out_root === 16'h0, "R4", out_root, 0);
    @(negedge clk);
    rst_n = 1'b1;
    send(32'd169, "R6");
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    test_reset();
    test_small();
    test_top();
    test_squares();
    test_gap_hold();
    test_stream();
    test_random();
    test_mid_reset();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule